// File: doc/BRIEF.md
# Mode-Scheduled Frequency Oscillator

This block is the digital timebase for a half-bridge lamp inverter. A phase accumulator adds a step to itself once per clock. The top bit of the accumulator is a 50% square wave that drives the two switches alternately. The step is the base run-frequency tuning word scaled by a multiplier. The start-up sequencer's mode and the start-up timer voltage (in millivolts) choose that multiplier.

During filament warm-up the multiplier is fixed at 1.6. During the strike phase the multiplier glides linearly from 1.6 down to 1.0 as the timer climbs from 3 V to 5 V. In steady running, and while the dead-time loop is active, the multiplier stays at 1.0 whatever the timer does. In lockout and in latched shutdown the accumulator is cleared and both outputs stay low.

A package function turns a timing-resistor value into the base tuning word using f = 4·10⁹ / R. The accumulator loads a new step only when it wraps, so a change of setting never produces a short or stretched half period. Each toggle of the square wave is flagged by a one-cycle pulse for the downstream dead-time generator.

Top module: `osc_mode_sched`

## Requirements
- R1: Mode codes 0 (lockout), 5 (shutdown), 6 and 7 are idle. From the second clock edge after an idle code is presented, `phase_o` and `edge_o` stay low and the accumulator is cleared. When a running code is then applied, the first clock edge only loads the step. Every later edge adds one step, so `phase_o` first goes high at edge k+1, where k is the least integer with k·step ≥ 2^(ACC_W−1).
- R2: `phase_o` is the top bit of the accumulator, so its high and low times each last half the period to within one clock.
- R3: In mode 3 (run) and mode 4 (dead-time regulation) the period is 2^ACC_W / base_word clocks, independent of `timer_mv_i`.
- R4: In mode 1 (warm-up) the frequency is 1.6 × the run frequency, independent of `timer_mv_i`.
- R5: In mode 2 (strike) the frequency is run × (1 + 0.3·(5 − V)), with V = `timer_mv_i`/1000 clamped to the range 3.0 V to 5.0 V. The multiplier is held in fixed point with FRAC fractional bits and always lies between 1.0 and 1.6.
- R6: Mode, timer and base word are sampled only on the clock edge at which the accumulator overflows (the falling edge of `phase_o`). The half period in progress finishes at the old step.
- R7: `edge_o` is high for exactly the cycles in which `phase_o` differs from its value one cycle earlier while running. This gives two pulses per period. It is never high otherwise.
- R8: The package function `run_tuning_word(r_ohm, fclk_hz, acc_w)` returns floor(4·10⁹·2^acc_w / (r_ohm·fclk_hz)): 16777 for 80 kΩ at 50 MHz with 24 bits.
- R9: While `rst_ni` is low, `phase_o` and `edge_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_word_i | input | TW_W | Run-frequency tuning word (added per clock at multiplier 1.0) |
| mode_i | input | 3 | Sequencer mode: 0 lockout, 1 warm-up, 2 strike, 3 run, 4 dead-time regulation, 5 shutdown, 6–7 idle |
| timer_mv_i | input | MV_W | Start-up timer voltage in millivolts |
| phase_o | output | 1 | 50% square-wave phase |
| edge_o | output | 1 | One-cycle pulse on each phase toggle |

## Verification
The hardest behaviour to expose from the ports is the hold-until-wrap rule. A setting change that lands mid-period is invisible in an averaged frequency measurement; it shows up only in the length of the half period that was in progress. The stimulus watches for a rising edge of the phase and switches from run to warm-up at that exact moment. It then times the remaining high half, which must keep the run length, and the following low half, which must already be at the warm-up length. The strike glide is also driven outside its 3 V to 5 V window on both sides, to show that the clamp flattens the multiplier at 1.6 and 1.0.

// File: rtl/osc_sched_pkg.sv
package osc_sched_pkg;

    // sequencer mode codes
    localparam logic [2:0] MODE_LOCKOUT = 3'd0;
    localparam logic [2:0] MODE_PREHEAT = 3'd1;
    localparam logic [2:0] MODE_IGNITE  = 3'd2;
    localparam logic [2:0] MODE_RUN     = 3'd3;
    localparam logic [2:0] MODE_ZVS     = 3'd4;
    localparam logic [2:0] MODE_HALT    = 3'd5;

    // strike-glide timer window in millivolts
    localparam int IGN_LO_MV = 3000;
    localparam int IGN_HI_MV = 5000;

    // true for the four modes that switch the bridge
    function automatic logic mode_is_active(input logic [2:0] m);
        return (m == MODE_PREHEAT) || (m == MODE_IGNITE) ||
               (m == MODE_RUN)     || (m == MODE_ZVS);
    endfunction

    // R8: run tuning word from timing resistance, f = 4e9 / R
    function automatic longint unsigned run_tuning_word(
        input longint unsigned r_ohm,
        input longint unsigned fclk_hz,
        input int unsigned     acc_w
    );
        return (64'd4000000000 << acc_w) / (r_ohm * fclk_hz);
    endfunction

endpackage

// File: rtl/osc_mult_sched.sv
module osc_mult_sched
    import osc_sched_pkg::*;
#(
    parameter int FRAC = 12,
    parameter int MV_W = 13
) (
    input  logic [2:0]      mode_i,
    input  logic [MV_W-1:0] timer_mv_i,
    output logic [FRAC:0]   mult_o
);
    localparam int          MULT_W   = FRAC + 1;
    localparam longint      ONE      = longint'(1) << FRAC;
    localparam longint      PRE_MULT = (16 * ONE + 5) / 10;
    localparam int          IGN_SH   = 16;
    // 0.3 per volt expressed per millivolt, scaled by 2^IGN_SH
    localparam longint      IGN_K    = (3 * ONE * (longint'(1) << IGN_SH) + 5000) / 10000;
    localparam int          K_W      = $clog2(IGN_K + 1);
    localparam int          DELTA_W  = 11;
    localparam int          PROD_W   = DELTA_W + K_W;
    localparam logic [MV_W-1:0] LO_MV = MV_W'(IGN_LO_MV);
    localparam logic [MV_W-1:0] HI_MV = MV_W'(IGN_HI_MV);

    logic [MV_W-1:0]    mv_clamp;
    logic [DELTA_W-1:0] delta;
    logic [PROD_W-1:0]  ign_prod;
    logic [MULT_W-1:0]  ign_mult;

    always_comb begin
        // R5: clamp the timer to the glide window
        if (timer_mv_i < LO_MV) begin
            mv_clamp = LO_MV;
        end else if (timer_mv_i > HI_MV) begin
            mv_clamp = HI_MV;
        end else begin
            mv_clamp = timer_mv_i;
        end
        delta    = DELTA_W'(HI_MV - mv_clamp);
        ign_prod = PROD_W'(delta) * PROD_W'(IGN_K);
        ign_mult = MULT_W'(ONE) + MULT_W'(ign_prod >> IGN_SH);

        case (mode_i)
            MODE_PREHEAT: mult_o = MULT_W'(PRE_MULT);   // R4
            MODE_IGNITE:  mult_o = ign_mult;            // R5
            default:      mult_o = MULT_W'(ONE);        // R3
        endcase

        AST_MULT_BOUND: assert (mult_o >= MULT_W'(ONE) && mult_o <= MULT_W'(PRE_MULT))
            else $error("multiplier outside 1.0..1.6"); // R5
    end

endmodule

// File: rtl/osc_step_scale.sv
module osc_step_scale #(
    parameter int TW_W = 20,
    parameter int FRAC = 12
) (
    input  logic [TW_W-1:0] base_i,
    input  logic [FRAC:0]   mult_i,
    output logic [TW_W:0]   step_o
);
    localparam int PROD_W = TW_W + FRAC + 1;
    localparam int STEP_W = TW_W + 1;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod   = PROD_W'(base_i) * PROD_W'(mult_i);
        step_o = STEP_W'(prod >> FRAC);
    end

endmodule

// File: rtl/osc_phase_acc.sv
module osc_phase_acc #(
    parameter int ACC_W  = 24,
    parameter int STEP_W = 21
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              active_i,
    input  logic [STEP_W-1:0] step_new_i,
    output logic              phase_o,
    output logic              edge_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] step;
        logic             run;
        logic             tgl;
    } acc_state_t;

    acc_state_t       state_d, state_q;
    logic [ACC_W:0]   sum;
    logic             wrap;
    logic [ACC_W-1:0] step_ext;

    always_comb begin
        state_d     = state_q;
        state_d.tgl = 1'b0;
        step_ext    = ACC_W'(step_new_i);
        sum         = {1'b0, state_q.acc} + {1'b0, state_q.step};
        wrap        = 1'b0;
        if (!active_i) begin
            // R1: idle clears phase and keeps the step primed
            state_d.acc  = '0;
            state_d.run  = 1'b0;
            state_d.step = step_ext;
        end else if (!state_q.run) begin
            // first running edge only loads the step
            state_d.acc  = '0;
            state_d.run  = 1'b1;
            state_d.step = step_ext;
        end else begin
            state_d.acc = sum[ACC_W-1:0];
            wrap        = sum[ACC_W];
            if (wrap) begin
                state_d.step = step_ext;              // R6
            end
            state_d.tgl = sum[ACC_W-1] ^ state_q.acc[ACC_W-1]; // R7
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;                            // R9
        end else begin
            state_q <= state_d;
        end
    end

    assign phase_o = state_q.acc[ACC_W-1];            // R2
    assign edge_o  = state_q.tgl;

    AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active_i |=> (!phase_o && !edge_o)); // R1

    AST_EDGE_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_o |-> (phase_o != $past(phase_o))); // R7

    AST_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.run && active_i && !wrap) |=> $stable(state_q.step)); // R6

    AST_WRAP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.run && active_i && wrap) |=> !phase_o); // R2

endmodule

// File: rtl/osc_mode_sched.sv
module osc_mode_sched
    import osc_sched_pkg::*;
#(
    parameter int ACC_W = 24,
    parameter int TW_W  = 20,
    parameter int FRAC  = 12,
    parameter int MV_W  = 13
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [TW_W-1:0] base_word_i,
    input  logic [2:0]      mode_i,
    input  logic [MV_W-1:0] timer_mv_i,
    output logic            phase_o,
    output logic            edge_o
);
    localparam int MULT_W = FRAC + 1;
    localparam int STEP_W = TW_W + 1;

    logic [MULT_W-1:0] mult;
    logic [STEP_W-1:0] step_new;
    logic              active;

    assign active = mode_is_active(mode_i);

    osc_mult_sched #(.FRAC(FRAC), .MV_W(MV_W)) mult_i (
        .mode_i     (mode_i),
        .timer_mv_i (timer_mv_i),
        .mult_o     (mult)
    );

    osc_step_scale #(.TW_W(TW_W), .FRAC(FRAC)) scale_i (
        .base_i (base_word_i),
        .mult_i (mult),
        .step_o (step_new)
    );

    osc_phase_acc #(.ACC_W(ACC_W), .STEP_W(STEP_W)) acc_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .active_i   (active),
        .step_new_i (step_new),
        .phase_o    (phase_o),
        .edge_o     (edge_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        !rst_ni |-> (!phase_o && !edge_o)); // R9

endmodule

// File: tb/osc_mode_sched_tb_top.sv
module osc_mode_sched_tb_top;
    import osc_sched_pkg::*;

    localparam int ACC_W = 24;
    localparam int TW_W  = 20;
    localparam int FRAC  = 12;
    localparam int MV_W  = 13;
    localparam real FULL = 16777216.0;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [TW_W-1:0] base = '0;
    logic [2:0]      mode = 3'd0;
    logic [MV_W-1:0] mv = '0;
    logic            phase;
    logic            edg;

    always #10 clk = ~clk;

    osc_mode_sched #(.ACC_W(ACC_W), .TW_W(TW_W), .FRAC(FRAC), .MV_W(MV_W)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .base_word_i (base),
        .mode_i      (mode),
        .timer_mv_i  (mv),
        .phase_o     (phase),
        .edge_o      (edg)
    );

    typedef struct {
        real   ideal;
        string req;
    } exp_t;

    exp_t sb_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   edge_bad = 0;
    int   edge_missing = 0;
    bit   running = 1'b0;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input real act, input real expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, expv);
        end
    endtask

    function automatic bit near(input real a, input real b, input real tol);
        real d;
        d = a - b;
        if (d < 0.0) d = -d;
        return d <= tol;
    endfunction

    // monitor: measures rise-to-rise periods and pops the scoreboard
    logic prev_ph = 1'b0;
    int   since_rise = 0;
    always @(negedge clk) begin : monitor
        exp_t e;
        since_rise++;
        if (edg && (phase == prev_ph)) edge_bad++;                 // R7
        if (!edg && (phase != prev_ph) && running) edge_missing++; // R7
        if (phase && !prev_ph) begin
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                chk(near(real'(since_rise), e.ideal, 2.0 + 0.002 * e.ideal),
                    e.req, "period in clocks", real'(since_rise), e.ideal);
            end
            since_rise = 0;
        end
        prev_ph = phase;
    end

    task automatic wait_rises(input int n);
        int   seen = 0;
        logic p = phase;
        while (seen < n) begin
            @(negedge clk);
            if (phase && !p) seen++;
            p = phase;
        end
    endtask

    task automatic wait_level(input logic lvl, output int cycles);
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
        end while (phase != lvl);
    endtask

    // driver: apply a setting, let it settle past two wraps, queue expectation
    task automatic expect_period(input logic [2:0] m, input int v_mv, input int bw,
                                 input real mult, input string req);
        exp_t e;
        @(negedge clk);
        mode = m;
        mv   = MV_W'(v_mv);
        base = TW_W'(bw);
        running = 1'b1;
        wait_rises(3);
        @(negedge clk);
        e.ideal = FULL / (real'(bw) * mult);
        e.req   = req;
        sb_q.push_back(e);
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic idle_check(input logic [2:0] m, input string req);
        int bad = 0;
        @(negedge clk);
        running = 1'b0;
        mode = m;
        repeat (2) @(negedge clk);
        repeat (2000) begin
            @(negedge clk);
            if (phase || edg) bad++;
        end
        chk(bad == 0, req, "cycles with activity while idle", real'(bad), 0.0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL all requirements: watchdog expired, actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        int c_hi;
        int c_lo;
        int k;
        longint unsigned tw;

        // R9: reset state
        repeat (3) @(negedge clk);
        chk(!phase && !edg, "R9", "outputs during reset", real'({phase, edg}), 0.0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!phase && !edg, "R1", "outputs in lockout after reset", real'({phase, edg}), 0.0);

        // R8: tuning word from resistance
        tw = run_tuning_word(64'd80000, 64'd50000000, ACC_W);
        chk(tw == 64'd16777, "R8", "word for 80k", real'(tw),
            $floor(4.0e9 * FULL / (80000.0 * 50.0e6)));
        tw = run_tuning_word(64'd40000, 64'd50000000, ACC_W);
        chk(tw == 64'd33554, "R8", "word for 40k", real'(tw),
            $floor(4.0e9 * FULL / (40000.0 * 50.0e6)));

        // R3: run and regulation ignore the timer
        expect_period(MODE_RUN, 7000, 16777, 1.0, "R3");
        expect_period(MODE_ZVS, 6200, 16777, 1.0, "R3");
        expect_period(MODE_RUN, 2000, 16777, 1.0, "R3");
        expect_period(MODE_RUN, 7000, 33554, 1.0, "R3");
        // R4: warm-up at 1.6x
        expect_period(MODE_PREHEAT, 500, 16777, 1.6, "R4");
        expect_period(MODE_PREHEAT, 2900, 16777, 1.6, "R4");
        expect_period(MODE_PREHEAT, 1000, 10000, 1.6, "R4");
        // R5: strike glide and its clamp
        expect_period(MODE_IGNITE, 3000, 16777, 1.6, "R5");
        expect_period(MODE_IGNITE, 4000, 16777, 1.3, "R5");
        expect_period(MODE_IGNITE, 4500, 16777, 1.15, "R5");
        expect_period(MODE_IGNITE, 5000, 16777, 1.0, "R5");
        expect_period(MODE_IGNITE, 2000, 16777, 1.6, "R5");
        expect_period(MODE_IGNITE, 6500, 16777, 1.0, "R5");

        // R2: duty cycle at run
        expect_period(MODE_RUN, 7000, 16777, 1.0, "R2");
        wait_rises(1);
        wait_level(1'b0, c_hi);
        wait_level(1'b1, c_lo);
        chk(near(real'(c_hi), 500.0, 1.5), "R2", "high time", real'(c_hi), 500.0);
        chk(near(real'(c_hi), real'(c_lo), 1.5), "R2", "high vs low time",
            real'(c_hi), real'(c_lo));

        // R6: switch to warm-up exactly at a rising edge
        wait_rises(1);
        mode = MODE_PREHEAT;
        wait_level(1'b0, c_hi);
        wait_level(1'b1, c_lo);
        chk(near(real'(c_hi), 500.0, 2.0), "R6", "half period after mid-period change",
            real'(c_hi), 500.0);
        chk(near(real'(c_lo), 312.5, 2.0), "R6", "first half at new setting",
            real'(c_lo), 312.5);

        // R1: idle codes and restart from zero phase
        idle_check(MODE_HALT, "R1");
        idle_check(3'd7, "R1");
        idle_check(MODE_LOCKOUT, "R1");
        @(negedge clk);
        base = TW_W'(16777);
        mode = MODE_RUN;
        running = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!phase && k < 5000);
        chk(near(real'(k), 502.0, 1.0), "R1", "clocks to first rise after restart",
            real'(k), 502.0);

        // R7: edge pulse coherence over the whole run
        chk(edge_bad == 0, "R7", "pulses without toggle", real'(edge_bad), 0.0);
        chk(edge_missing == 0, "R7", "toggles without pulse", real'(edge_missing), 0.0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule